// File: doc/BRIEF.md
# Receiver RF Gain Pad Controller

This block drives the single gain-select bit of a receiver RF front end. When an IF-stage saturation flag reports that the front end is close to clipping and the AGC has not yet locked on a packet, the block switches the front end to low gain by inserting a fixed attenuation pad. At the same moment it tells the attenuation accumulator to reload itself from a programmed threshold and tells the AGC to drop its lock, so the gain loop starts again from a known point.

The pad comes out again in two ways. While the AGC is unlocked, the pad is released when the accumulator falls strictly below the same programmed threshold, which undoes a pad that a noise spike put in. When receive enable drops, the pad is released whatever else is happening, including in the middle of a packet. While the AGC is locked, the pad state is frozen and both the saturation flag and the threshold compare are ignored. Typical settings are a 30 dB pad value and a 24 dB threshold, and both are supplied as register inputs.

The saturation flag comes from another chip and passes through a two-flop synchronizer before it is used. Reset is asserted asynchronously and released in step with the clock.

Top module: `rx_gain_pad_ctrl`

## Requirements
- R1: While reset is asserted and after it is released with no stimulus, `gain_hi_o` is 1 (high gain, pad out), `acc_load_o` and `agc_unlock_o` are 0 and `acc_preset_o` is 0.
- R2: `sat_det_i` is sampled by two synchronizer flops. A 1 that is set up before rising edge k, with `rx_en_i`=1 and `agc_locked_i`=0, makes `gain_hi_o` go to 0 (pad in) after rising edge k+2.
- R3: In the first cycle of each engagement, `acc_load_o` and `agc_unlock_o` are 1 for exactly one cycle, and `acc_preset_o` holds the `thresh_cfg_i` value that was present at the engaging edge. `acc_preset_o` keeps that value until the next engagement.
- R4: While `agc_locked_i`=1 and `rx_en_i`=1, `gain_hi_o` does not change: the saturation flag cannot engage the pad and the threshold compare cannot release it.
- R5: While unlocked and enabled, an engaged pad is released at the next edge if `atten_acc_i` < `thresh_cfg_i` as unsigned values. If the two are equal or the accumulator is higher, the pad stays in.
- R6: The release compare is ignored in the cycle in which `acc_load_o` is 1, because the accumulator has not yet taken its preset value.
- R7: `rx_en_i`=0 sampled at an edge releases the pad at that edge, even while the AGC is locked. If it coincides with a qualifying saturation flag, release wins and no load or unlock pulse is issued.
- R8: `pad_atten_o` equals `pad_atten_cfg_i` while the pad is in and 0 while it is out.
- R9: A saturation flag that arrives while the pad is already in produces no further load or unlock pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| sat_det_i | input | 1 | IF saturation flag, asynchronous to clk |
| agc_locked_i | input | 1 | AGC has locked on a packet |
| rx_en_i | input | 1 | Receive enable |
| atten_acc_i | input | ACC_W | Attenuation accumulator value, unsigned dB |
| pad_atten_cfg_i | input | ACC_W | Programmed pad attenuation, dB |
| thresh_cfg_i | input | ACC_W | Programmed preset value and release threshold, dB |
| gain_hi_o | output | 1 | 1 = high gain (pad out), 0 = low gain (pad in) |
| acc_load_o | output | 1 | One-cycle request to load the accumulator |
| acc_preset_o | output | ACC_W | Value the accumulator is to load |
| agc_unlock_o | output | 1 | One-cycle request forcing the AGC out of lock |
| pad_atten_o | output | ACC_W | Attenuation now contributed by the pad |

## Verification
A saturation flag reaches the gain bit three rising edges after it is applied, because two synchronizer stages come before the pad register. The load and unlock pulses appear in the same cycle as the first low-gain output. Lock, enable and accumulator inputs act on the next edge. The bench drives inputs on falling edges. A bench model advances by one edge for each driven cycle, and every output is compared on the next falling edge, so each compare sees exactly the results of the edges that came before it. Directed sequences pin the equal-threshold case, the suppressed compare during the load cycle, the collision of a disable with an engagement, and a frozen pad under lock. After them comes a long random run.

// File: rtl/rfpad_pkg.sv
package rfpad_pkg;
  typedef enum logic {
    PAD_OUT = 1'b0,
    PAD_IN  = 1'b1
  } pad_state_e;

  localparam int unsigned SYNC_STAGES_DEF = 2;
endpackage

// File: rtl/rfpad_rst_sync.sv
module rfpad_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/rfpad_bit_sync.sv
module rfpad_bit_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb stage_d = d_i;
    end else begin : g_many
      always_comb stage_d = {stage_q[STAGES-2:0], d_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/rfpad_ctrl.sv
module rfpad_ctrl
  import rfpad_pkg::*;
#(
  parameter int unsigned ACC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sat_s_i,
  input  logic             locked_i,
  input  logic             rx_en_i,
  input  logic [ACC_W-1:0] acc_i,
  input  logic [ACC_W-1:0] thresh_i,
  input  logic [ACC_W-1:0] pad_cfg_i,
  output logic             gain_hi_o,
  output logic             load_o,
  output logic             unlock_o,
  output logic [ACC_W-1:0] preset_o,
  output logic [ACC_W-1:0] pad_atten_o
);
  pad_state_e       pad_q, pad_d;
  logic             load_q;
  logic             engage;
  logic             below_thr;
  logic             preset_en;
  logic [ACC_W-1:0] preset_q;

  assign below_thr = (acc_i < thresh_i);

  always_comb begin
    pad_d  = pad_q;
    engage = 1'b0;
    if (!rx_en_i) begin
      pad_d = PAD_OUT;
    end else if (!locked_i) begin
      if (pad_q == PAD_OUT) begin
        if (sat_s_i) begin
          pad_d  = PAD_IN;
          engage = 1'b1;
        end
      end else if (!load_q && below_thr) begin
        pad_d = PAD_OUT;
      end
    end
  end

  assign preset_en = engage;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pad_q    <= PAD_OUT;
      load_q   <= 1'b0;
      preset_q <= '0;
    end else begin
      pad_q  <= pad_d;
      load_q <= engage;
      if (preset_en) preset_q <= thresh_i;
    end
  end

  assign gain_hi_o   = (pad_q == PAD_OUT);
  assign load_o      = load_q;
  assign unlock_o    = load_q;
  assign preset_o    = preset_q;
  assign pad_atten_o = (pad_q == PAD_IN) ? pad_cfg_i : '0;
endmodule

// File: rtl/rx_gain_pad_ctrl.sv
module rx_gain_pad_ctrl
  import rfpad_pkg::*;
#(
  parameter int unsigned ACC_W       = 8,
  parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sat_det_i,
  input  logic             agc_locked_i,
  input  logic             rx_en_i,
  input  logic [ACC_W-1:0] atten_acc_i,
  input  logic [ACC_W-1:0] pad_atten_cfg_i,
  input  logic [ACC_W-1:0] thresh_cfg_i,
  output logic             gain_hi_o,
  output logic             acc_load_o,
  output logic [ACC_W-1:0] acc_preset_o,
  output logic             agc_unlock_o,
  output logic [ACC_W-1:0] pad_atten_o
);
  logic rst_n_int;
  logic sat_s;

  rfpad_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  rfpad_bit_sync #(.STAGES(SYNC_STAGES)) i_sat_sync (
    .clk   (clk),
    .rst_n (rst_n_int),
    .d_i   (sat_det_i),
    .q_o   (sat_s)
  );

  rfpad_ctrl #(.ACC_W(ACC_W)) i_ctrl (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .sat_s_i     (sat_s),
    .locked_i    (agc_locked_i),
    .rx_en_i     (rx_en_i),
    .acc_i       (atten_acc_i),
    .thresh_i    (thresh_cfg_i),
    .pad_cfg_i   (pad_atten_cfg_i),
    .gain_hi_o   (gain_hi_o),
    .load_o      (acc_load_o),
    .unlock_o    (agc_unlock_o),
    .preset_o    (acc_preset_o),
    .pad_atten_o (pad_atten_o)
  );
endmodule

// File: rtl/rx_gain_pad_ctrl_chk.sv
module rx_gain_pad_ctrl_chk #(
  parameter int unsigned ACC_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             agc_locked_i,
  input logic             rx_en_i,
  input logic [ACC_W-1:0] atten_acc_i,
  input logic [ACC_W-1:0] thresh_cfg_i,
  input logic             gain_hi_o,
  input logic             acc_load_o,
  input logic             agc_unlock_o,
  input logic [ACC_W-1:0] pad_atten_o
);
  // R3
  load_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_load_o |=> !acc_load_o);

  // R3
  load_low_gain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_load_o |-> (!gain_hi_o && agc_unlock_o));

  // R3
  engage_pulses_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gain_hi_o) |-> acc_load_o);

  // R4
  lock_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (agc_locked_i && rx_en_i) |=> $stable(gain_hi_o));

  // R5
  equal_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en_i && !agc_locked_i && !gain_hi_o && !acc_load_o &&
     (atten_acc_i >= thresh_cfg_i)) |=> !gain_hi_o);

  // R6
  load_cycle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_load_o && rx_en_i && !agc_locked_i) |=> !gain_hi_o);

  // R7
  rx_off_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en_i |=> (gain_hi_o && !acc_load_o));

  // R8
  pad_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gain_hi_o |-> (pad_atten_o == '0));
endmodule

bind rx_gain_pad_ctrl rx_gain_pad_ctrl_chk #(.ACC_W(ACC_W)) i_chk (.*);

// File: tb/test_rx_gain_pad_ctrl.sv
module test_rx_gain_pad_ctrl;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned W          = 8;
  localparam int unsigned N_RANDOM   = 4000;
  localparam int unsigned WATCHDOG   = 200000;

  logic         clk;
  logic         rst_n;
  logic         sat_det_i, agc_locked_i, rx_en_i;
  logic [W-1:0] atten_acc_i, pad_atten_cfg_i, thresh_cfg_i;
  logic         gain_hi_o, acc_load_o, agc_unlock_o;
  logic [W-1:0] acc_preset_o, pad_atten_o;

  int unsigned n_chk, n_fail;
  bit          done;

  // bench model state
  bit         m_s1, m_s2, m_pad, m_load;
  logic [W-1:0] m_preset;
  string      cur_tag;

  rx_gain_pad_ctrl #(.ACC_W(W)) i_rx_gain_pad_ctrl (
    .clk             (clk),
    .rst_n           (rst_n),
    .sat_det_i       (sat_det_i),
    .agc_locked_i    (agc_locked_i),
    .rx_en_i         (rx_en_i),
    .atten_acc_i     (atten_acc_i),
    .pad_atten_cfg_i (pad_atten_cfg_i),
    .thresh_cfg_i    (thresh_cfg_i),
    .gain_hi_o       (gain_hi_o),
    .acc_load_o      (acc_load_o),
    .acc_preset_o    (acc_preset_o),
    .agc_unlock_o    (agc_unlock_o),
    .pad_atten_o     (pad_atten_o)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  task automatic check(input string tag, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] exp_pad_atten(input bit pad, input logic [W-1:0] cfg);
    return pad ? cfg : '0;
  endfunction

  // compare at the current falling edge, then drive and advance the model
  task automatic step(input bit sat, input bit lk, input bit en,
                      input logic [W-1:0] acc, input logic [W-1:0] th,
                      input logic [W-1:0] pc, input string tag);
    bit pad_n, eng;
    @(negedge clk);
    check(cur_tag, "gain_hi",  {{(W-1){1'b0}}, gain_hi_o},    {{(W-1){1'b0}}, !m_pad});
    check(cur_tag, "acc_load", {{(W-1){1'b0}}, acc_load_o},   {{(W-1){1'b0}}, m_load});
    check(cur_tag, "unlock",   {{(W-1){1'b0}}, agc_unlock_o}, {{(W-1){1'b0}}, m_load});
    check(cur_tag, "preset",   acc_preset_o, m_preset);
    check(cur_tag, "pad_atten", pad_atten_o, exp_pad_atten(m_pad, pad_atten_cfg_i));
    sat_det_i = sat; agc_locked_i = lk; rx_en_i = en;
    atten_acc_i = acc; thresh_cfg_i = th; pad_atten_cfg_i = pc;
    cur_tag = tag;
    pad_n = m_pad; eng = 1'b0;
    if (!en) pad_n = 1'b0;
    else if (!lk) begin
      if (!m_pad) begin
        if (m_s2) begin pad_n = 1'b1; eng = 1'b1; end
      end else if (!m_load && (acc < th)) pad_n = 1'b0;
    end
    if (eng) m_preset = th;
    m_pad  = pad_n;
    m_load = eng;
    m_s2   = m_s1;
    m_s1   = sat;
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    n_chk = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0;
    sat_det_i = 0; agc_locked_i = 0; rx_en_i = 0;
    atten_acc_i = 0; pad_atten_cfg_i = 8'd30; thresh_cfg_i = 8'd24;
    repeat (3) @(negedge clk);
    // R1 reset values while reset is held
    check("R1", "gain_hi",  {{(W-1){1'b0}}, gain_hi_o},    8'd1);
    check("R1", "acc_load", {{(W-1){1'b0}}, acc_load_o},   8'd0);
    check("R1", "unlock",   {{(W-1){1'b0}}, agc_unlock_o}, 8'd0);
    check("R1", "preset",   acc_preset_o, 8'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    m_s1 = 0; m_s2 = 0; m_pad = 0; m_load = 0; m_preset = '0;
    cur_tag = "R1";
    step(0, 0, 1, 8'd50, 8'd24, 8'd30, "R1");

    // R2 R3 R8: single-cycle flag engages after the synchronizer
    step(1, 0, 1, 8'd50, 8'd24, 8'd30, "R2");
    step(0, 0, 1, 8'd50, 8'd24, 8'd30, "R2");
    step(0, 0, 1, 8'd50, 8'd24, 8'd30, "R3");
    step(0, 0, 1, 8'd50, 8'd24, 8'd30, "R8");
    // R9: flag again while the pad is in
    step(1, 0, 1, 8'd50, 8'd24, 8'd30, "R9");
    repeat (3) step(0, 0, 1, 8'd50, 8'd24, 8'd30, "R9");
    // R5: equal keeps the pad in, one below releases it
    repeat (2) step(0, 0, 1, 8'd24, 8'd24, 8'd30, "R5");
    step(0, 0, 1, 8'd23, 8'd24, 8'd30, "R5");
    step(0, 0, 1, 8'd23, 8'd24, 8'd30, "R5");
    // R6: accumulator below threshold during the load cycle
    step(1, 0, 1, 8'd0, 8'd40, 8'd30, "R6");
    repeat (5) step(0, 0, 1, 8'd0, 8'd40, 8'd30, "R6");
    // R4: locked with pad in and accumulator low, then flag while locked
    step(1, 0, 1, 8'd90, 8'd40, 8'd30, "R4");
    repeat (3) step(0, 0, 1, 8'd90, 8'd40, 8'd30, "R4");
    repeat (3) step(1, 1, 1, 8'd0, 8'd40, 8'd30, "R4");
    // R7: enable low releases mid-packet while locked
    step(0, 1, 0, 8'd90, 8'd40, 8'd30, "R7");
    repeat (2) step(0, 1, 1, 8'd0, 8'd40, 8'd30, "R4");
    step(0, 0, 1, 8'd90, 8'd40, 8'd30, "R4");
    // R7: enable low in the cycle the synchronized flag qualifies
    step(1, 0, 1, 8'd90, 8'd40, 8'd30, "R7");
    step(1, 0, 1, 8'd90, 8'd40, 8'd30, "R7");
    step(0, 0, 0, 8'd90, 8'd40, 8'd30, "R7");
    step(0, 0, 1, 8'd90, 8'd40, 8'd30, "R7");
    repeat (3) step(0, 0, 1, 8'd90, 8'd40, 8'd30, "R7");

    for (int i = 0; i < N_RANDOM; i++) begin
      bit sat, lk, en;
      sat = ($urandom % 100) < 15;
      lk  = ($urandom % 100) < 30;
      en  = ($urandom % 100) < 92;
      step(sat, lk, en, W'($urandom % 64), W'(16 + $urandom % 32),
           W'($urandom), "random");
    end
    step(0, 0, 0, 8'd0, 8'd24, 8'd30, "random");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule